// File: doc/BRIEF.md
# Page-Wrapping Word Address Counter with Write Staging

This block keeps the current word address of a byte-wide serial memory array and a one-page staging buffer for writes. The array is divided into pages of 2^PAGE_W bytes (16 by default). With ADDR_W = 10 there are 64 pages; with ADDR_W = 9 there are 32. A bus slave engine drives it with single-cycle strobes. It loads an address made of high page bits and a low address byte. It opens a write transaction, hands over each received data byte, and advances the address after each byte sent on a read. When the page write is committed, it takes the staged page.

How the address advances depends on the direction. For a write step, only the low PAGE_W bits count, so the page row stays fixed and a page boundary wraps back to the first byte of the same page. For a read step, the whole address counts and wraps from the last byte of the array to zero. Each staged byte carries an enable flag. On commit, the write controller receives the page row, every lane's data and the enable flags, so only bytes actually received are written. Between transactions the address stays where the last step left it, which serves current-address reads.

Top module: `eeprom_addr_stage`

## Requirements
- R1: After reset, addr_o is 0, every bit of cm_be_o is 0 and every data lane of cm_data_o is 0.
- R2: A cycle with ld_i high sets addr_o on the next cycle to {ld_hi_i, ld_lo_i}, with ld_hi_i as the most significant bits.
- R3: A cycle with wr_byte_i high stores wr_data_i in the lane whose number equals addr_o[PAGE_W-1:0] and sets that lane's enable bit cm_be_o[lane]. On the next cycle the low PAGE_W bits of addr_o have advanced by one and the upper bits are unchanged.
- R4: A write step from a lane of all ones returns the low PAGE_W bits to 0 in the same row. A 17th byte therefore overwrites the lane of the first byte of that transaction.
- R5: A cycle with rd_step_i high advances the full addr_o by one on the next cycle, and 2^ADDR_W-1 rolls to 0.
- R6: In a cycle with none of ld_i, wr_byte_i or rd_step_i, addr_o is unchanged.
- R7: A cycle with wr_open_i high clears every enable bit. If wr_byte_i is high in the same cycle, only the enable of that byte's lane is set afterwards. Data lanes are never cleared, and lanes that are not written keep their earlier contents.
- R8: cm_valid_o equals commit_i in the same cycle. While commit_i is high, cm_row_o is addr_o[ADDR_W-1:PAGE_W], lane i of cm_data_o is bits [i*DATA_W +: DATA_W] and its enable is cm_be_o[i], all taken from the state before that clock edge. A wr_open_i in the same cycle therefore does not alter what is presented.
- R9: After a committed write, addr_o holds the wrapped position that follows the last byte written, so a later read step starts there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_i | input | 1 | Load the address |
| ld_hi_i | input | ADDR_W-8 | Page bits above the low byte |
| ld_lo_i | input | 8 | Low address byte |
| wr_open_i | input | 1 | Start of a write transaction |
| wr_byte_i | input | 1 | A data byte was received |
| wr_data_i | input | DATA_W | The received byte |
| rd_step_i | input | 1 | A byte was sent on a read |
| commit_i | input | 1 | Commit the staged page |
| addr_o | output | ADDR_W | Current word address |
| cm_valid_o | output | 1 | Commit presentation valid |
| cm_row_o | output | ADDR_W-PAGE_W | Page row to be written |
| cm_data_o | output | 2^PAGE_W*DATA_W | Staged data of all lanes |
| cm_be_o | output | 2^PAGE_W | Per-lane write enables |

## Verification
Two pairs of functions can land in the same cycle. In the first, the opening of a write transaction meets the first data byte: the clear and the set of enables must resolve so that only that byte's lane remains enabled. In the second, a commit meets the opening of the next transaction: the presented enables and data must still be those of the finished transaction. The random stimulus raises wr_open_i together with wr_byte_i, and commit_i together with wr_open_i, at a fixed rate. The bench compares the commit outputs, sampled before the edge, and the enable flags, sampled after it, against its own page model.

// File: rtl/wac_pkg.sv
package wac_pkg;

  // Mask covering the low pw bits of a 16-bit address.
  function automatic logic [15:0] low_mask(input int unsigned pw);
    return 16'((32'd1 << pw) - 32'd1);
  endfunction

  // Write step: advance only inside the page, keep the row bits.
  function automatic logic [15:0] page_step(input logic [15:0] a, input int unsigned pw);
    logic [15:0] m;
    m = low_mask(pw);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

  // Read step: advance across the whole address, caller truncates.
  function automatic logic [15:0] lin_step(input logic [15:0] a);
    return a + 16'd1;
  endfunction

  // Lane number of an address within its page.
  function automatic logic [15:0] lane_of(input logic [15:0] a, input int unsigned pw);
    return a & low_mask(pw);
  endfunction

endpackage

// File: rtl/wac_addr_ctr.sv
module wac_addr_ctr
  import wac_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              wstep,
  input  logic              rstep,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_wr_nxt;
  logic [ADDR_W-1:0] addr_rd_nxt;

  always_comb begin
    addr_wr_nxt = ADDR_W'(page_step(16'(addr_q), PAGE_W));
    addr_rd_nxt = ADDR_W'(lin_step(16'(addr_q)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     addr_q <= '0;
    else if (load)  addr_q <= load_addr;
    else if (wstep) addr_q <= addr_wr_nxt;
    else if (rstep) addr_q <= addr_rd_nxt;
  end

  assign addr = addr_q;

endmodule

// File: rtl/wac_lane.sv
module wac_lane #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q,
  output logic              en
);

  logic [DATA_W-1:0] q_r;
  logic              en_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r  <= '0;
      en_r <= 1'b0;
    end else begin
      if (wr) q_r <= d;
      // a write in the same cycle as a clear wins for its own lane
      if (wr)       en_r <= 1'b1;
      else if (clr) en_r <= 1'b0;
    end
  end

  assign q  = q_r;
  assign en = en_r;

endmodule

// File: rtl/wac_page_buf.sv
module wac_page_buf #(
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clr,
  input  logic                               wr,
  input  logic [PAGE_W-1:0]                  lane_sel,
  input  logic [DATA_W-1:0]                  d,
  output logic [(1<<PAGE_W)*DATA_W-1:0]      data_flat,
  output logic [(1<<PAGE_W)-1:0]             be
);

  localparam int unsigned NB = 1 << PAGE_W;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic hit;
    assign hit = wr && (lane_sel == PAGE_W'(i));
    wac_lane #(.DATA_W(DATA_W)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .wr   (hit),
      .d    (d),
      .q    (data_flat[i*DATA_W +: DATA_W]),
      .en   (be[i])
    );
  end

endmodule

// File: rtl/eeprom_addr_stage.sv
module eeprom_addr_stage
  import wac_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ld_i,
  input  logic [ADDR_W-9:0]              ld_hi_i,
  input  logic [7:0]                     ld_lo_i,
  input  logic                           wr_open_i,
  input  logic                           wr_byte_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  input  logic                           rd_step_i,
  input  logic                           commit_i,
  output logic [ADDR_W-1:0]              addr_o,
  output logic                           cm_valid_o,
  output logic [ADDR_W-PAGE_W-1:0]       cm_row_o,
  output logic [(1<<PAGE_W)*DATA_W-1:0]  cm_data_o,
  output logic [(1<<PAGE_W)-1:0]         cm_be_o
);

  localparam int unsigned NB    = 1 << PAGE_W;
  localparam int unsigned ROW_W = ADDR_W - PAGE_W;

  // named internal events, observed by the bound checker
  logic              evt_load;
  logic              evt_wstep;
  logic              evt_rstep;
  logic              evt_clear;
  logic [PAGE_W-1:0] lane_sel;
  logic [ADDR_W-1:0] cur_addr;

  assign evt_load  = ld_i;
  assign evt_wstep = wr_byte_i;
  assign evt_rstep = rd_step_i;
  assign evt_clear = wr_open_i;

  wac_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (evt_load),
    .load_addr({ld_hi_i, ld_lo_i}),
    .wstep    (evt_wstep),
    .rstep    (evt_rstep),
    .addr     (cur_addr)
  );

  assign lane_sel = PAGE_W'(lane_of(16'(cur_addr), PAGE_W));

  logic [NB*DATA_W-1:0] stage_data;
  logic [NB-1:0]        stage_be;

  wac_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (evt_clear),
    .wr       (evt_wstep),
    .lane_sel (lane_sel),
    .d        (wr_data_i),
    .data_flat(stage_data),
    .be       (stage_be)
  );

  assign addr_o     = cur_addr;
  assign cm_valid_o = commit_i;
  assign cm_row_o   = cur_addr[ADDR_W-1:PAGE_W];
  assign cm_data_o  = stage_data;
  assign cm_be_o    = stage_be;

  logic [ROW_W-1:0] row_unused;
  assign row_unused = cm_row_o;

endmodule

// File: rtl/wac_chk.sv
module wac_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned PAGE_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      addr_o,
  input logic [(1<<PAGE_W)-1:0] cm_be_o,
  input logic                   evt_load,
  input logic                   evt_wstep,
  input logic                   evt_rstep,
  input logic                   evt_clear,
  input logic [ADDR_W-9:0]      ld_hi_i,
  input logic [7:0]             ld_lo_i,
  input logic [PAGE_W-1:0]      lane_sel
);

  a_r2_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
    evt_load |=> addr_o == $past({ld_hi_i, ld_lo_i}));

  a_r3_row_held: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wstep && !evt_load) |=> addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W]));

  a_r3_lane_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wstep |=> cm_be_o[$past(lane_sel)]);

  a_r4_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wstep && !evt_load && (&addr_o[PAGE_W-1:0])) |=> addr_o[PAGE_W-1:0] == '0);

  a_r5_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rstep && !evt_load && !evt_wstep) |=> addr_o == ADDR_W'($past(addr_o) + 1'b1));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_load && !evt_wstep && !evt_rstep) |=> $stable(addr_o));

  a_r7_open_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clear && !evt_wstep) |=> cm_be_o == '0);

  a_r7_open_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clear && evt_wstep) |=> $countones(cm_be_o) == 1);

endmodule

bind eeprom_addr_stage wac_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr_o   (addr_o),
  .cm_be_o  (cm_be_o),
  .evt_load (evt_load),
  .evt_wstep(evt_wstep),
  .evt_rstep(evt_rstep),
  .evt_clear(evt_clear),
  .ld_hi_i  (ld_hi_i),
  .ld_lo_i  (ld_lo_i),
  .lane_sel (lane_sel)
);

// File: tb/eeprom_addr_stage_tb.sv
module eeprom_addr_stage_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int PW = 4;
  localparam int DW = 8;
  localparam int NB = 16;

  logic clk = 0, rst_n = 0;
  logic ld = 0, wo = 0, wb = 0, rs = 0, cm = 0;
  logic [AW-9:0] hi = 0;
  logic [7:0] lo = 0;
  logic [DW-1:0] wd = 0;
  logic [AW-1:0] addr;
  logic cmv;
  logic [AW-PW-1:0] row;
  logic [NB*DW-1:0] cdata;
  logic [NB-1:0] cbe;

  int n_tests = 0, n_fail = 0;
  int m_addr;
  logic [7:0] m_data [NB];
  logic m_be [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_addr_stage #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_i(ld), .ld_hi_i(hi), .ld_lo_i(lo),
    .wr_open_i(wo), .wr_byte_i(wb), .wr_data_i(wd), .rd_step_i(rs),
    .commit_i(cm), .addr_o(addr), .cm_valid_o(cmv), .cm_row_o(row),
    .cm_data_o(cdata), .cm_be_o(cbe));

  function automatic logic [NB-1:0] exp_be();
    logic [NB-1:0] v;
    for (int i = 0; i < NB; i++) v[i] = m_be[i];
    return v;
  endfunction

  function automatic logic [NB*DW-1:0] exp_data();
    logic [NB*DW-1:0] v;
    for (int i = 0; i < NB; i++) v[i*DW +: DW] = m_data[i];
    return v;
  endfunction

  // write step in the bench's own terms: row kept, lane counts modulo 16
  function automatic int next_w(int a);
    return (a / NB) * NB + ((a % NB) + 1) % NB;
  endfunction

  function automatic int next_r(int a);
    return (a + 1) % (1 << AW);
  endfunction

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit l, input int la, input bit o, input bit b,
                      input logic [7:0] d, input bit r, input bit c, input string req);
    int lane;
    @(negedge clk);
    ld = l; hi = (AW-8)'(la >> 8); lo = 8'(la); wo = o; wb = b; wd = d; rs = r; cm = c;
    #1;
    if (c) begin
      chk({req, " R8 valid"}, 256'(cmv), 256'(1));
      chk({req, " R8 row"}, 256'(row), 256'(m_addr / NB));
      chk({req, " R8 be"}, 256'(cbe), 256'(exp_be()));
      chk({req, " R8 data"}, 256'(cdata), 256'(exp_data()));
    end
    @(posedge clk); #1;
    if (o) for (int i = 0; i < NB; i++) m_be[i] = 0;
    if (b) begin
      lane = m_addr % NB;
      m_data[lane] = d;
      m_be[lane] = 1;
    end
    if (l) m_addr = la;
    else if (b) m_addr = next_w(m_addr);
    else if (r) m_addr = next_r(m_addr);
    chk({req, " addr"}, 256'(addr), 256'(m_addr));
    chk({req, " be"}, 256'(cbe), 256'(exp_be()));
    ld = 0; wo = 0; wb = 0; rs = 0; cm = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    int k;
    seed = $urandom(32'h5eed_0a1c);
    m_addr = 0;
    for (int i = 0; i < NB; i++) begin m_data[i] = 0; m_be[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 addr", 256'(addr), 256'(0));
    chk("R1 be", 256'(cbe), 256'(0));
    chk("R1 data", 256'(cdata), 256'(0));
    @(negedge clk); rst_n = 1;

    // R2 load, R5 read roll at end of array
    step(1, 1022, 0, 0, 0, 0, 0, "R2 load");
    step(0, 0, 0, 0, 0, 1, 0, "R5 read");
    step(0, 0, 0, 0, 0, 1, 0, "R5 roll");
    chk("R5 zero", 256'(addr), 256'(0));
    step(0, 0, 0, 0, 0, 0, 0, "R6 idle");

    // R4: 18 bytes into one page starting at lane 14, open with first byte (R7)
    step(1, 16 * 37 + 14, 0, 0, 0, 0, 0, "R2 load page");
    for (int i = 0; i < 18; i++)
      step(0, 0, i == 0, 1, 8'(8'hA0 + i), 0, 0, i == 0 ? "R7 open+byte" : "R3 R4 write");
    chk("R4 row kept", 256'(addr / NB), 256'(37));
    chk("R4 overwrite", 256'(cdata[14*DW +: DW]), 256'(8'hB0));
    // R8 commit together with next open, R9 address after commit
    step(0, 0, 1, 0, 0, 0, 1, "R8 R7 commit+open");
    chk("R9 addr", 256'(addr), 256'(16 * 37 + 0));
    step(0, 0, 0, 0, 0, 1, 0, "R9 read after commit");

    for (int n = 0; n < 600; n++) begin
      k = $urandom_range(0, 9);
      case (k)
        0: step(1, $urandom_range(0, 1023), 0, 0, 0, 0, 0, "R2 rnd");
        1: step(0, 0, 1, 1, 8'($urandom), 0, 0, "R7 rnd");
        2: step(0, 0, 1, 0, 0, 0, 1, "R8 rnd");
        3: step(0, 0, 0, 0, 0, 0, $urandom_range(0, 1), "R6 rnd");
        4, 5: step(0, 0, 0, 0, 0, 1, 0, "R5 rnd");
        default: step(0, 0, 0, 1, 8'($urandom), 0, $urandom_range(0, 1), "R3 rnd");
      endcase
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule